// File: doc/BRIEF.md
# Page Replacement Unit with Selectable FIFO or LRU Victim Order

This block tracks which pages sit in a small, fully associative page store of a parameterised number of frames. One page number may be presented per clock cycle. The block answers each reference with a hit or miss flag and with the frame that now holds the page. On a miss with every frame occupied, it also reports which page was thrown out.

When a miss finds a frame still empty, the lowest-numbered empty frame is taken and no page is evicted. Once every frame is occupied, a victim is chosen in one of two ways, set by a static policy input. In insertion order (FIFO), the page that entered earliest goes out. In recency order (LRU), the page referenced least recently goes out. Running hit and miss totals let the two policies be compared on the same reference trace. A synchronous clear returns the store to empty and zeroes both totals.

Top module: `page_repl_unit`

## Requirements
- R1: While rst_ni is low and after its release, resp_valid_o, hit_o and evict_valid_o are 0, both counters are 0 and all frames are empty.
- R2: A reference to a resident page gives hit_o=1, frame_o equal to the frame holding the page, and evict_valid_o=0.
- R3: A miss while some frame is empty places the page in the lowest-numbered empty frame, reports that frame on frame_o, and gives evict_valid_o=0.
- R4: With mode_lru_i=0 (FIFO), a miss with all frames full replaces the page that was inserted earliest, and hits do not change that order.
- R5: With mode_lru_i=1 (LRU), a miss with all frames full replaces the page whose latest reference (hit or insertion) is oldest.
- R6: On a replacement, evict_valid_o=1, evict_page_o carries the removed page number, and frame_o names the frame that now holds the new page.
- R7: Every accepted reference adds exactly one to hit_cnt_o on a hit or to miss_cnt_o on a miss. The updated totals appear in the same cycle as that reference's response.
- R8: resp_valid_o is 1 in exactly the cycle after a reference is accepted (ref_valid_i=1 and clear_i=0). hit_o, frame_o, evict_valid_o and evict_page_o are valid in that cycle.
- R9: clear_i=1 empties all frames and zeroes both counters in the next cycle. It takes priority over a reference presented in the same cycle, which is then ignored.
- R10: In a cycle with ref_valid_i=0 and clear_i=0, neither counter nor any frame changes.
- R11: On the trace 2 3 2 1 5 2 4 5 3 2 5 2 from an empty three-frame store, LRU ends with 5 hits and 7 misses, and FIFO ends with 3 hits and 9 misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of frames and counters |
| mode_lru_i | input | 1 | Victim policy: 0 insertion order, 1 recency order |
| ref_valid_i | input | 1 | A page reference is presented |
| ref_page_i | input | PAGE_W | Referenced page number |
| resp_valid_o | output | 1 | Response for the previous cycle's reference |
| hit_o | output | 1 | Page was resident |
| frame_o | output | IDX_W | Frame now holding the page |
| evict_valid_o | output | 1 | A resident page was replaced |
| evict_page_o | output | PAGE_W | Page number that was replaced |
| hit_cnt_o | output | CNT_W | Hits since reset or clear |
| miss_cnt_o | output | CNT_W | Misses since reset or clear |

## Verification
The assertions assume that mode_lru_i changes only in a cycle where clear_i is high, so that one policy applies to the whole run between two clears. The stimulus changes the mode only inside its clear task. The assertions also assume that the counters do not wrap, and every run is far shorter than 2^CNT_W references. The duplicate-match check relies on the block's own rule that a hit never inserts a page. The bench drives arbitrary page numbers, including repeats, and keeps them inside PAGE_W.

// File: rtl/page_repl_pkg.sv
package page_repl_pkg;
  typedef enum logic {
    POL_FIFO = 1'b0,
    POL_LRU  = 1'b1
  } policy_e;
endpackage

// File: rtl/pr_lookup.sv
module pr_lookup #(
  parameter int NUM_FRAMES = 3,
  parameter int PAGE_W     = 8,
  localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_FRAMES-1:0] valid_i,
  input  logic [PAGE_W-1:0]     tag_i [NUM_FRAMES],
  input  logic [PAGE_W-1:0]     page_i,
  output logic                  hit_o,
  output logic [IDX_W-1:0]      hit_idx_o,
  output logic                  full_o,
  output logic [IDX_W-1:0]      free_idx_o
);
  logic [NUM_FRAMES-1:0] match;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tag_i[g] == page_i);
  end

  assign hit_o  = |match;
  assign full_o = &valid_i;

  always_comb begin
    hit_idx_o  = '0;
    free_idx_o = '0;
    for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
      if (match[i])    hit_idx_o  = IDX_W'(i);
      if (!valid_i[i]) free_idx_o = IDX_W'(i);
    end
  end

  // R2: a page is never resident in two frames
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/pr_age.sv
module pr_age #(
  parameter int NUM_FRAMES = 3,
  localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_idx_o
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_FRAMES - 1);

  // rank 0 = newest, NUM_FRAMES-1 = oldest; ranks stay a permutation
  logic [IDX_W-1:0]      rank_q [NUM_FRAMES];
  logic [NUM_FRAMES-1:0] oldest_vec;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_rank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rank_q[g] <= IDX_W'(g);
      end else if (clear_i) begin
        rank_q[g] <= IDX_W'(g);
      end else if (touch_i) begin
        if (touch_idx_i == IDX_W'(g))            rank_q[g] <= '0;
        else if (rank_q[g] < rank_q[touch_idx_i]) rank_q[g] <= rank_q[g] + 1'b1;
      end
    end
    assign oldest_vec[g] = (rank_q[g] == OLDEST);
  end

  always_comb begin
    victim_idx_o = '0;
    for (int i = 0; i < NUM_FRAMES; i++)
      if (oldest_vec[i]) victim_idx_o = IDX_W'(i);
  end

  // R4 R5: exactly one frame is oldest at all times
  one_oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(oldest_vec));

  // R4 R5: a touched frame becomes newest
  touch_newest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (touch_i && !clear_i) |=> (rank_q[$past(touch_idx_i)] == '0));
endmodule

// File: rtl/pr_counter.sv
module pr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clear_i) cnt_o <= '0;
    else if (inc_i)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/page_repl_unit.sv
module page_repl_unit
  import page_repl_pkg::*;
#(
  parameter int NUM_FRAMES = 3,
  parameter int PAGE_W     = 8,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              mode_lru_i,
  input  logic              ref_valid_i,
  input  logic [PAGE_W-1:0] ref_page_i,
  output logic              resp_valid_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  frame_o,
  output logic              evict_valid_o,
  output logic [PAGE_W-1:0] evict_page_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  logic [PAGE_W-1:0]     tag_q [NUM_FRAMES];
  logic [NUM_FRAMES-1:0] valid_q;

  logic             lk_hit, lk_full;
  logic [IDX_W-1:0] lk_hit_idx, lk_free_idx, victim_idx, sel_idx;
  logic             accept, touch, evict;
  policy_e          policy;

  assign policy = policy_e'(mode_lru_i);
  assign accept = ref_valid_i && !clear_i;

  pr_lookup #(.NUM_FRAMES(NUM_FRAMES), .PAGE_W(PAGE_W)) u_lookup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_q),
    .tag_i      (tag_q),
    .page_i     (ref_page_i),
    .hit_o      (lk_hit),
    .hit_idx_o  (lk_hit_idx),
    .full_o     (lk_full),
    .free_idx_o (lk_free_idx)
  );

  always_comb begin
    if (lk_hit)       sel_idx = lk_hit_idx;
    else if (lk_full) sel_idx = victim_idx;
    else              sel_idx = lk_free_idx;
    evict = accept && !lk_hit && lk_full;
    // insertion always touches; a hit touches only in recency mode
    touch = accept && (!lk_hit || policy == POL_LRU);
  end

  pr_age #(.NUM_FRAMES(NUM_FRAMES)) u_age (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .touch_i      (touch),
    .touch_idx_i  (sel_idx),
    .victim_idx_o (victim_idx)
  );

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (clear_i) begin
        valid_q[g] <= 1'b0;
      end else if (accept && !lk_hit && sel_idx == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= ref_page_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o  <= 1'b0;
      hit_o         <= 1'b0;
      frame_o       <= '0;
      evict_valid_o <= 1'b0;
      evict_page_o  <= '0;
    end else begin
      resp_valid_o  <= accept;
      hit_o         <= accept && lk_hit;
      evict_valid_o <= evict;
      if (accept) begin
        frame_o      <= sel_idx;
        evict_page_o <= evict ? tag_q[victim_idx] : '0;
      end
    end
  end

  pr_counter #(.CNT_W(CNT_W)) u_hit_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .inc_i   (accept && lk_hit),
    .cnt_o   (hit_cnt_o)
  );

  pr_counter #(.CNT_W(CNT_W)) u_miss_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .inc_i   (accept && !lk_hit),
    .cnt_o   (miss_cnt_o)
  );

  logic [CNT_W-1:0] cnt_sum;
  assign cnt_sum = hit_cnt_o + miss_cnt_o;

  // R8
  resp_follows_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> resp_valid_o);

  // R8
  no_spurious_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !resp_valid_o);

  // R6
  evict_on_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> (resp_valid_o && !hit_o));

  // R7
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (cnt_sum == $past(cnt_sum) + 1'b1));

  // R9
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (hit_cnt_o == '0 && miss_cnt_o == '0 && valid_q == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_valid_i && !clear_i) |=> ($stable(hit_cnt_o) && $stable(miss_cnt_o) && $stable(valid_q)));

  // R3: filling a free frame never reports an eviction
  fill_no_evict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !lk_hit && !lk_full) |=> !evict_valid_o);
endmodule

// File: tb/tb_page_repl_unit.sv
module tb_page_repl_unit;
  localparam int NF = 3;
  localparam int PW = 8;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clear_i = 1'b0;
  logic          mode_lru_i = 1'b0;
  logic          ref_valid_i = 1'b0;
  logic [PW-1:0] ref_page_i = '0;
  logic          resp_valid_o, hit_o, evict_valid_o;
  logic [1:0]    frame_o;
  logic [PW-1:0] evict_page_o;
  logic [CW-1:0] hit_cnt_o, miss_cnt_o;

  always #10 clk_i = ~clk_i;

  page_repl_unit #(.NUM_FRAMES(NF), .PAGE_W(PW), .CNT_W(CW)) dut (
    .clk_i, .rst_ni, .clear_i, .mode_lru_i, .ref_valid_i, .ref_page_i,
    .resp_valid_o, .hit_o, .frame_o, .evict_valid_o, .evict_page_o,
    .hit_cnt_o, .miss_cnt_o
  );

  typedef struct {
    bit    hit;
    int    frame;
    bit    ev;
    int    evpage;
    int    hc;
    int    mc;
    string req;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;

  int m_page[NF];
  bit m_val[NF];
  int m_stamp[NF];
  int now_t = 0;
  int m_hc = 0;
  int m_mc = 0;
  bit m_lru = 0;

  task automatic chk(bit ok, string req, int act, int exp_v, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NF; i++) begin
      m_val[i] = 0; m_page[i] = 0; m_stamp[i] = 0;
    end
    m_hc = 0; m_mc = 0;
  endtask

  task automatic do_ref(int p);
    exp_t e;
    int f;
    @(negedge clk_i);
    e.hit = 0; e.ev = 0; e.evpage = 0; f = -1;
    for (int i = 0; i < NF; i++)
      if (m_val[i] && m_page[i] == p) f = i;
    if (f >= 0) begin
      e.hit = 1; e.req = "R2";
      if (m_lru) m_stamp[f] = now_t;
      m_hc++;
    end else begin
      for (int i = NF - 1; i >= 0; i--)
        if (!m_val[i]) f = i;
      if (f >= 0) begin
        e.req = "R3";
      end else begin
        f = 0;
        for (int i = 1; i < NF; i++)
          if (m_stamp[i] < m_stamp[f]) f = i;
        e.ev = 1; e.evpage = m_page[f];
        e.req = m_lru ? "R5" : "R4";
      end
      m_page[f] = p; m_val[f] = 1; m_stamp[f] = now_t;
      m_mc++;
    end
    now_t++;
    e.frame = f; e.hc = m_hc; e.mc = m_mc;
    q.push_back(e);
    ref_valid_i = 1'b1;
    ref_page_i  = PW'(p);
  endtask

  task automatic idle(int n);
    @(negedge clk_i);
    ref_valid_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  // clear with a reference presented in the same cycle (must be ignored)
  task automatic do_clear(bit lru, int stray_page);
    @(negedge clk_i);
    clear_i = 1'b1; mode_lru_i = lru;
    ref_valid_i = 1'b1; ref_page_i = PW'(stray_page);
    model_clear();
    m_lru = lru;
    @(negedge clk_i);
    clear_i = 1'b0; ref_valid_i = 1'b0;
    // R9
    chk(hit_cnt_o == 0, "R9", int'(hit_cnt_o), 0, "hit count after clear");
    chk(miss_cnt_o == 0, "R9", int'(miss_cnt_o), 0, "miss count after clear");
    chk(resp_valid_o == 0, "R9", int'(resp_valid_o), 0, "response to ignored reference");
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && resp_valid_o) begin
      if (q.size() == 0) begin
        chk(0, "R8", 1, 0, "response without reference");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(hit_o == e.hit, e.req, int'(hit_o), int'(e.hit), "hit flag");
        chk(int'(frame_o) == e.frame, e.req, int'(frame_o), e.frame, "frame");
        chk(evict_valid_o == e.ev, "R6", int'(evict_valid_o), int'(e.ev), "evict flag");
        if (e.ev)
          chk(int'(evict_page_o) == e.evpage, "R6", int'(evict_page_o), e.evpage, "evicted page");
        chk(int'(hit_cnt_o) == e.hc, "R7", int'(hit_cnt_o), e.hc, "hit count");
        chk(int'(miss_cnt_o) == e.mc, "R7", int'(miss_cnt_o), e.mc, "miss count");
      end
    end
  end

  bit done = 0;
  initial begin
    #(20ns * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  int trace[12] = '{2, 3, 2, 1, 5, 2, 4, 5, 3, 2, 5, 2};

  initial begin
    int lfsr;
    model_clear();
    repeat (3) @(negedge clk_i);
    // R1
    chk(resp_valid_o == 0 && hit_o == 0 && evict_valid_o == 0, "R1",
        int'(resp_valid_o), 0, "outputs in reset");
    chk(hit_cnt_o == 0 && miss_cnt_o == 0, "R1", int'(hit_cnt_o + miss_cnt_o), 0, "counters in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(resp_valid_o == 0, "R1", int'(resp_valid_o), 0, "no response after release");

    // R3: empty store fills frames 0,1,2; R1: first reference misses
    do_ref(9); do_ref(9); do_ref(4); do_ref(6);
    idle(2);
    // R10, R8: idle cycles change nothing and produce no response
    chk(resp_valid_o == 0, "R8", int'(resp_valid_o), 0, "response during idle");
    chk(int'(hit_cnt_o) == m_hc, "R10", int'(hit_cnt_o), m_hc, "hit count after idle");
    chk(int'(miss_cnt_o) == m_mc, "R10", int'(miss_cnt_o), m_mc, "miss count after idle");
    do_ref(9); do_ref(4); do_ref(6);   // all resident: R10 kept frames
    idle(1);

    // R11 and R5: recency trace
    do_clear(1'b1, 2);
    foreach (trace[i]) do_ref(trace[i]);
    idle(2);
    chk(hit_cnt_o == 5, "R11", int'(hit_cnt_o), 5, "LRU hits on trace");
    chk(miss_cnt_o == 7, "R11", int'(miss_cnt_o), 7, "LRU misses on trace");

    // R11 and R4: insertion-order trace
    do_clear(1'b0, 3);
    foreach (trace[i]) do_ref(trace[i]);
    idle(2);
    chk(hit_cnt_o == 3, "R11", int'(hit_cnt_o), 3, "FIFO hits on trace");
    chk(miss_cnt_o == 9, "R11", int'(miss_cnt_o), 9, "FIFO misses on trace");

    // R4: repeated hits on the oldest page do not save it
    do_clear(1'b0, 0);
    do_ref(10); do_ref(11); do_ref(12); do_ref(10); do_ref(10); do_ref(13); do_ref(10);
    idle(2);

    // pseudo-random mixes under both policies with gaps
    for (int pass = 0; pass < 2; pass++) begin
      do_clear(pass[0], 1);
      lfsr = 8'h5a + pass;
      for (int n = 0; n < 300; n++) begin
        lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 8'hff;
        do_ref(lfsr % 6);
        if (lfsr[2:0] == 3'd0) idle(1);
      end
      idle(2);
    end

    chk(q.size() == 0, "R8", q.size(), 0, "pending expected responses");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule